// File: doc/BRIEF.md
# Load address and data aligner

This block serves a multicycle 32-bit core that runs one instruction through several states in turn. During the execute state of a load, it forms the memory read address from the base register value and the 12-bit signed offset in the instruction. It keeps only the two low address bits. In the instruction-read state it passes the program counter through as the read address, so the same memory port serves instruction fetch as well.

One state later, in the wait-for-load state, the block takes the 32-bit word returned by memory. It picks out the byte, halfword or word that the load asks for, extends it with sign or zeros, and registers the destination index, the value and a write-back strobe for the register file. A halfword may start at byte offset 0, 1 or 2, because all three stay inside the word. An access that would cross the word boundary is not carried out. Instead it raises a one-cycle error flag and suppresses the write-back.

Top module: `load_align_unit`

## Requirements
- R1: When `core_state` is 1 (instruction read), `mem_addr` equals `pc` in the same cycle.
- R2: When `core_state` is 2 (execute) and `instr[6:0]` is 7'b0000011, `mem_addr` equals `rs1_val` plus `instr[31:20]` sign-extended from bit 11. In every other case (state 0, state 3, or execute with another opcode) `mem_addr` is 0.
- R3: The two low bits of the load address are captured at the clock edge that ends an execute-state load cycle. They keep their value through every other cycle, including an execute cycle with a non-load opcode.
- R4: In state 3 (wait for load), `instr[14:12]` = 0 (signed byte) or 4 (unsigned byte) takes `rd_data` bits [8*off+7 : 8*off] for offset off = 0..3. It sign-extends from bit 7 for code 0 and zero-extends for code 4.
- R5: In state 3, code 1 (signed halfword) or 5 (unsigned halfword) at offset 0, 1 or 2 takes `rd_data` bits [8*off+15 : 8*off]. It sign-extends from bit 15 for code 1 and zero-extends for code 5.
- R6: In state 3, code 2 (word) at offset 0 writes the whole `rd_data`.
- R7: In state 3, a halfword load at offset 3 or a word load at offset 1, 2 or 3 raises `misalign_err` for exactly one cycle and leaves `dst_we` low.
- R8: In state 3, any other code (3, 6 or 7) writes register 0 with value 0, with `dst_we` high.
- R9: The write-back outputs are registered. `dst_we` and `misalign_err` are high only in the cycle right after a state-3 cycle, and never both at once. `dst_idx` is `instr[11:7]` for a supported load.
- R10: After reset, `dst_we`, `misalign_err`, `dst_idx` and `dst_val` are 0 and the captured offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_state | input | 3 | Core state: 0 other, 1 instruction read, 2 execute, 3 wait for load |
| pc | input | 32 | Program counter |
| instr | input | 32 | Current instruction word |
| rs1_val | input | 32 | Base register value |
| rd_data | input | 32 | Word read from memory |
| mem_addr | output | 32 | Memory read address |
| dst_idx | output | 5 | Destination register index |
| dst_val | output | 32 | Destination register value |
| dst_we | output | 1 | Write-back strobe |
| misalign_err | output | 1 | Word-crossing load error pulse |

## Verification
The bench targets the corner cases of this block. Byte offset 3 for byte loads checks that a wrong shift is caught, because it would return a lower byte. Halfword offsets 1 and 2 are legal, so a design that treated them as faults would drop the write. Offset 3 must raise the error, so a design that read past the word would write a truncated value instead. Values with the top bit set at each position separate sign extension from zero extension.

An execute cycle with a non-load opcode, placed between a load's execute and its wait state, exposes a design that recaptures the offset on every execute cycle. Unsupported codes check the write of zero to register 0. Random loads compared with a bench model cover the remaining mix.

// File: rtl/ldal_pkg.sv
package ldal_pkg;
  localparam int XLEN    = 32;
  localparam int STATE_W = 3;

  localparam logic [STATE_W-1:0] ST_FETCH = 3'd1;
  localparam logic [STATE_W-1:0] ST_EXEC  = 3'd2;
  localparam logic [STATE_W-1:0] ST_WAITL = 3'd3;

  localparam logic [6:0] OPC_LOAD = 7'b0000011;

  localparam logic [2:0] F3_SB  = 3'd0;
  localparam logic [2:0] F3_SH  = 3'd1;
  localparam logic [2:0] F3_W   = 3'd2;
  localparam logic [2:0] F3_UB  = 3'd4;
  localparam logic [2:0] F3_UH  = 3'd5;

  typedef struct packed {
    logic            ok;     // access stays inside the word
    logic            known;  // funct3 is a load type
    logic [XLEN-1:0] val;
  } align_res_t;

  function automatic logic [XLEN-1:0] sext12(input logic [11:0] v);
    return {{(XLEN-12){v[11]}}, v};
  endfunction

  function automatic align_res_t align_word(input logic [XLEN-1:0] w,
                                            input logic [1:0] off,
                                            input logic [2:0] f3);
    align_res_t r;
    logic [XLEN-1:0] sh;
    sh = w >> {off, 3'b000};
    r.ok = 1'b1;
    r.known = 1'b1;
    r.val = '0;
    case (f3)
      F3_SB: r.val = {{(XLEN-8){sh[7]}}, sh[7:0]};
      F3_UB: r.val = {{(XLEN-8){1'b0}}, sh[7:0]};
      F3_SH: begin
        r.ok = (off != 2'd3);
        r.val = {{(XLEN-16){sh[15]}}, sh[15:0]};
      end
      F3_UH: begin
        r.ok = (off != 2'd3);
        r.val = {{(XLEN-16){1'b0}}, sh[15:0]};
      end
      F3_W: begin
        r.ok = (off == 2'd0);
        r.val = w;
      end
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ldal_addr_gen.sv
module ldal_addr_gen
  import ldal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] core_state,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    instr,
  input  logic [XLEN-1:0]    rs1_val,
  output logic [XLEN-1:0]    mem_addr,
  output logic [1:0]         byte_off
);
  logic            is_load_exec;
  logic [XLEN-1:0] eff_addr;

  assign is_load_exec = (core_state == ST_EXEC) && (instr[6:0] == OPC_LOAD);
  assign eff_addr     = rs1_val + sext12(instr[31:20]);

  always_comb begin
    if (core_state == ST_FETCH)  mem_addr = pc;
    else if (is_load_exec)       mem_addr = eff_addr;
    else                         mem_addr = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            byte_off <= 2'd0;
    else if (is_load_exec) byte_off <= eff_addr[1:0];
  end

  p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_load_exec |=> $stable(byte_off));
  p_off_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_load_exec |=> byte_off == $past(mem_addr[1:0]));
endmodule

// File: rtl/ldal_data_align.sv
module ldal_data_align
  import ldal_pkg::*;
(
  input  logic [XLEN-1:0] rd_data,
  input  logic [1:0]      byte_off,
  input  logic [2:0]      funct3,
  output logic            acc_ok,
  output logic            acc_known,
  output logic [XLEN-1:0] acc_val
);
  align_res_t res;
  assign res       = align_word(rd_data, byte_off, funct3);
  assign acc_ok    = res.ok;
  assign acc_known = res.known;
  assign acc_val   = res.val;
endmodule

// File: rtl/ldal_wb_stage.sv
module ldal_wb_stage
  import ldal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_wait,
  input  logic [4:0]         rd_field,
  input  logic [2:0]         funct3,
  input  logic               acc_ok,
  input  logic               acc_known,
  input  logic [XLEN-1:0]    acc_val,
  output logic [4:0]         dst_idx,
  output logic [XLEN-1:0]    dst_val,
  output logic               dst_we,
  output logic               misalign_err
);
  logic fault_now;
  assign fault_now = in_wait && acc_known && !acc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_idx      <= '0;
      dst_val      <= '0;
      dst_we       <= 1'b0;
      misalign_err <= 1'b0;
    end else begin
      dst_we       <= in_wait && !fault_now;
      misalign_err <= fault_now;
      if (in_wait && !fault_now) begin
        dst_idx <= acc_known ? rd_field : 5'd0;
        dst_val <= acc_known ? acc_val  : '0;
      end
    end
  end

  p_we_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_we && misalign_err));
  p_strobe_after_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we || misalign_err) |-> $past(in_wait));
  p_unsigned_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && funct3 == F3_UB) |=> dst_val[XLEN-1:8] == '0);
  p_bad_code_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !acc_known) |=> (dst_we && dst_idx == 5'd0 && dst_val == '0));
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import ldal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        core_state,
  input  logic [31:0]       pc,
  input  logic [31:0]       instr,
  input  logic [31:0]       rs1_val,
  input  logic [31:0]       rd_data,
  output logic [31:0]       mem_addr,
  output logic [4:0]        dst_idx,
  output logic [31:0]       dst_val,
  output logic              dst_we,
  output logic              misalign_err
);
  logic [1:0]      byte_off;
  logic            acc_ok;
  logic            acc_known;
  logic [XLEN-1:0] acc_val;
  logic            in_wait;

  assign in_wait = (core_state == ST_WAITL);

  ldal_addr_gen u_addr (
    .clk(clk), .rst_n(rst_n), .core_state(core_state), .pc(pc),
    .instr(instr), .rs1_val(rs1_val), .mem_addr(mem_addr), .byte_off(byte_off)
  );

  ldal_data_align u_align (
    .rd_data(rd_data), .byte_off(byte_off), .funct3(instr[14:12]),
    .acc_ok(acc_ok), .acc_known(acc_known), .acc_val(acc_val)
  );

  ldal_wb_stage u_wb (
    .clk(clk), .rst_n(rst_n), .in_wait(in_wait), .rd_field(instr[11:7]),
    .funct3(instr[14:12]), .acc_ok(acc_ok), .acc_known(acc_known),
    .acc_val(acc_val), .dst_idx(dst_idx), .dst_val(dst_val),
    .dst_we(dst_we), .misalign_err(misalign_err)
  );

  p_fetch_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (core_state == ST_FETCH) |-> mem_addr == pc);
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> !dst_we);
endmodule

// File: tb/load_align_unit_tb.sv
module load_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  core_state = 3'd0;
  logic [31:0] pc = '0, instr = '0, rs1_val = '0, rd_data = '0;
  logic [31:0] mem_addr, dst_val;
  logic [4:0]  dst_idx;
  logic        dst_we, misalign_err;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  load_align_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_load(input logic [11:0] imm, input logic [2:0] f3,
                                          input logic [4:0] rd);
    return {imm, 5'd3, f3, rd, 7'b0000011};
  endfunction

  // expected result: {we, err, idx, value} computed from the requirements
  function automatic logic [38:0] model(input logic [31:0] w, input logic [1:0] off,
                                        input logic [2:0] f3, input logic [4:0] rd);
    logic [7:0] b; logic [15:0] h;
    b = w[8*off +: 8];
    h = (off == 2'd3) ? 16'h0 : w[8*off +: 16];
    case (f3)
      3'd0: return {1'b1, 1'b0, rd, {{24{b[7]}}, b}};
      3'd4: return {1'b1, 1'b0, rd, {24'h0, b}};
      3'd1: return (off == 2'd3) ? {1'b0, 1'b1, 5'd0, 32'd0} : {1'b1, 1'b0, rd, {{16{h[15]}}, h}};
      3'd5: return (off == 2'd3) ? {1'b0, 1'b1, 5'd0, 32'd0} : {1'b1, 1'b0, rd, {16'h0, h}};
      3'd2: return (off != 2'd0) ? {1'b0, 1'b1, 5'd0, 32'd0} : {1'b1, 1'b0, rd, w};
      default: return {1'b1, 1'b0, 5'd0, 32'd0};
    endcase
  endfunction

  // one load: execute cycle, optional non-load execute, wait cycle, observe
  task automatic do_load(input logic [31:0] base, input logic [11:0] imm, input logic [2:0] f3,
                         input logic [4:0] rd, input logic [31:0] w, input bit interpose,
                         input string tag);
    logic [31:0] ea; logic [38:0] e;
    ea = base + {{20{imm[11]}}, imm};
    @(negedge clk);
    core_state = 3'd2; instr = mk_load(imm, f3, rd); rs1_val = base;
    #1 chk({tag, " R2 addr"}, mem_addr, ea);
    if (interpose) begin
      @(negedge clk);
      core_state = 3'd2; instr = {12'h7ff, 5'd3, 3'd0, rd, 7'b0010011}; rs1_val = base + 1;
      #1 chk("R2 non-load exec addr", mem_addr, 32'd0);
    end
    @(negedge clk);
    core_state = 3'd3; instr = mk_load(imm, f3, rd); rd_data = w;
    #1 chk("R2 wait addr", mem_addr, 32'd0);
    chk({tag, " R9 no early strobe"}, {31'd0, dst_we | misalign_err}, 32'd0);
    @(negedge clk);
    core_state = 3'd0; rd_data = $urandom;
    e = model(w, ea[1:0], f3, rd);
    #1;
    chk({tag, " R9 we"}, {31'd0, dst_we}, {31'd0, e[38]});
    chk({tag, " R7 err"}, {31'd0, misalign_err}, {31'd0, e[37]});
    if (e[38]) begin
      chk({tag, " R9 idx"}, {27'd0, dst_idx}, {27'd0, e[36:32]});
      chk({tag, " val"}, dst_val, e[31:0]);
    end
    @(negedge clk);
    #1 chk({tag, " R7 one-cycle pulse"}, {31'd0, dst_we | misalign_err}, 32'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a_73c1));
    repeat (3) @(negedge clk);
    chk("R10 we", {31'd0, dst_we}, 32'd0);
    chk("R10 err", {31'd0, misalign_err}, 32'd0);
    chk("R10 idx", {27'd0, dst_idx}, 32'd0);
    chk("R10 val", dst_val, 32'd0);
    rst_n = 1'b1;
    // R10 offset reset: wait-state word load without prior execute uses offset 0
    @(negedge clk);
    core_state = 3'd3; instr = mk_load(12'h0, 3'd2, 5'd9); rd_data = 32'hcafe_f00d;
    @(negedge clk); core_state = 3'd0;
    #1 chk("R10 offset zero word", dst_val, 32'hcafe_f00d);
    // R1 fetch
    @(negedge clk);
    core_state = 3'd1; pc = 32'h0000_0074;
    #1 chk("R1 fetch addr", mem_addr, 32'h74);
    pc = 32'hdead_beec;
    #1 chk("R1 fetch addr2", mem_addr, 32'hdead_beec);
    core_state = 3'd0;
    #1 chk("R2 idle addr", mem_addr, 32'd0);
    // R4 bytes, every offset, sign and zero
    for (int o = 0; o < 4; o++) begin
      do_load(32'h1000, 12'(o), 3'd0, 5'd5, 32'h80c0_a090, 0, "R4 lb");
      do_load(32'h1000, 12'(o), 3'd4, 5'd6, 32'h80c0_a090, 0, "R4 lbu");
    end
    // R5 halves at legal offsets, R7 at offset 3
    for (int o = 0; o < 4; o++) begin
      do_load(32'h2003, 12'hffd + 12'(o), 3'd1, 5'd7, 32'h8f01_9e02, 0, "R5 lh");
      do_load(32'h2003, 12'hffd + 12'(o), 3'd5, 5'd8, 32'h8f01_9e02, 0, "R5 lhu");
    end
    // R6 word, R7 misaligned words
    for (int o = 0; o < 4; o++)
      do_load(32'h3000, 12'(o), 3'd2, 5'd31, 32'h1234_abcd, 0, "R6 lw");
    // R8 unsupported codes
    do_load(32'h10, 12'h4, 3'd3, 5'd12, 32'hffff_ffff, 0, "R8 code3");
    do_load(32'h10, 12'h4, 3'd6, 5'd12, 32'hffff_ffff, 0, "R8 code6");
    do_load(32'h10, 12'h4, 3'd7, 5'd12, 32'hffff_ffff, 0, "R8 code7");
    // R3 non-load execute between capture and use
    do_load(32'h4000, 12'h3, 3'd0, 5'd3, 32'hab00_0000, 1, "R3 hold lb");
    do_load(32'h4000, 12'h2, 3'd1, 5'd4, 32'h8765_0000, 1, "R3 hold lh");
    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [2:0] f3;
      f3 = 3'($urandom);
      if (($urandom % 4) != 0) f3 = (($urandom % 2) != 0) ? 3'd0 + 3'($urandom % 3) : 3'd4 + 3'($urandom % 2);
      do_load($urandom, 12'($urandom), f3, 5'($urandom), $urandom, ($urandom % 5) == 0, "RND");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule